// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple request/ready interface and an asynchronous-style DRAM. The DRAM has one shared address bus and two active-low strobes. The controller first opens a row: it drives the row half of the request address and pulls the row strobe low. It then performs column accesses on that row by pulsing only the column strobe. For each column pulse it either samples one read word from the DRAM data input or drives one write word out. Each pulse transfers one word.

The controller remembers which row is open. A request to that same row goes straight to a column pulse and does not reopen the row. A request to any other row first raises the row strobe for a fixed precharge time and then opens the new row. When no request is waiting, the row stays open so that later accesses can still hit it. Only reset closes it. The row-to-column delay, the column pulse width, the precharge time and the read-sample point are fixed cycle counts set by parameters.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, the outputs are idle: `dramRasN`=1, `dramCasN`=1, `dramWeN`=1, `dramDoutEn`=0, `rdValid`=0 and `reqReady`=1.
- R2: An accepted request while no row is open gives this sequence:
  - `dramRasN` goes low with the row field `reqAddr[ADDR_W-1:COL_W]` on `dramAddr` for T_RCD cycles.
  - `dramCasN` then goes low with the column field `reqAddr[COL_W-1:0]` on the low bits of `dramAddr`.
  - A read's data appears on `rdValid` T_RCD+T_CL cycles after the accepting edge.
- R3: A request to the row that is already open causes no `dramRasN` transition. Only a column pulse follows, and a read's `rdValid` comes T_CL cycles after the accepting edge.
- R4: A request to a different row while a row is open first raises `dramRasN` for exactly T_RP cycles. It then opens the new row as in R2, and a read completes T_RP+T_RCD+T_CL cycles after acceptance.
- R5: Every access gives exactly one `dramCasN` low pulse, lasting exactly T_CAS cycles.
- R6: A read's word is `dramDin` sampled at the T_CL-th rising edge after `dramCasN` falls. It is presented on `rdData` together with a `rdValid` pulse that lasts one cycle.
- R7: During a write's column pulse, `dramWeN` is low and `dramDoutEn` is high for all T_CAS cycles, with `reqWdata` on `dramDout`. A write gives no `rdValid`.
- R8: `reqReady` drops in the cycle after a request is accepted. It returns T_CAS cycles after the column pulse starts, so a request is only taken with `reqReady` high.
- R9: With no request pending, an open row stays open (`dramRasN` stays low).
- R10: Reset closes an open row (`dramRasN` high), so the next access opens the row again as in R2.
- R11: `dramCasN` is never low while `dramRasN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; closes the row |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at an edge when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| reqWdata | input | DATA_W | Write word |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | DATA_W | Read word |
| dramAddr | output | max(ROW_W,COL_W) | Shared row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramDoutEn | output | 1 | Enable for the write-data driver |
| dramDout | output | DATA_W | Write data toward DRAM |
| dramDin | input | DATA_W | Read data from DRAM |

## Verification
The hardest case to reach from the ports is a row miss while a row is open and idle. It needs a row to be opened, left open with no request for a while, and then a request to a different row. The vector table orders its requests so that hits, misses and writes follow one another on the same open row. Directed steps then idle a row for many cycles before hitting it, and apply reset to an open row. A DRAM model in the bench records the strobe edges, the pulse widths and the latched addresses, and returns a marker value outside the column pulse so that a mistimed sample shows up.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_CLOSED,
    ST_ACT,
    ST_RW,
    ST_OPEN,
    ST_PRE
  } fpmState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic takeReq;
    logic selCol;
    logic capture;
  } fpmStrobe_t;

endpackage

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fpmStrobe_t             strb,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic                   reqWrite,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W-1:0]      dramDin,
  output logic                   rowHit,
  output logic                   curWrite,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]      dramDout,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic [DATA_W-1:0] curData;

  // request latch; curRow doubles as the open-row register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRow   <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curData  <= '0;
    end else if (strb.takeReq) begin
      curRow   <= reqAddr[ADDR_W-1:COL_W];
      curCol   <= reqAddr[COL_W-1:0];
      curWrite <= reqWrite;
      curData  <= reqWdata;
    end
  end

  assign rowHit   = (reqAddr[ADDR_W-1:COL_W] == curRow);
  assign dramAddr = strb.selCol ? MUX_W'(curCol) : MUX_W'(curRow);
  assign dramDout = curData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= dramDin;
    end
  end

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 3,
  parameter int T_CL  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  input  logic       curWrite,
  output logic       reqReady,
  output fpmStrobe_t strb,
  output logic       dramRasN,
  output logic       dramCasN,
  output logic       dramWeN,
  output logic       dramDoutEn
);
  localparam int MAX_AB = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int MAX_T  = (MAX_AB > T_RP) ? MAX_AB : T_RP;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  fpmState_e   state, nxt;
  logic [CNT_W-1:0] cnt;
  logic        accept;
  logic [7:0]  casRun;

  assign accept = reqValid && reqReady;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CLOSED: if (accept) nxt = ST_ACT;
      ST_ACT:    if (cnt == CNT_W'(T_RCD - 1)) nxt = ST_RW;
      ST_RW:     if (cnt == CNT_W'(T_CAS - 1)) nxt = ST_OPEN;
      ST_OPEN:   if (accept) nxt = rowHit ? ST_RW : ST_PRE;
      ST_PRE:    if (cnt == CNT_W'(T_RP - 1)) nxt = ST_ACT;
      default:   nxt = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_CLOSED;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || state == ST_OPEN || state == ST_CLOSED) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign reqReady     = (state == ST_CLOSED) || (state == ST_OPEN);
  assign dramRasN     = !((state == ST_ACT) || (state == ST_RW) || (state == ST_OPEN));
  assign dramCasN     = (state != ST_RW);
  assign dramWeN      = !((state == ST_RW) && curWrite);
  assign dramDoutEn   = (state == ST_RW) && curWrite;
  assign strb.takeReq = accept;
  assign strb.selCol  = (state == ST_RW);
  assign strb.capture = (state == ST_RW) && (cnt == CNT_W'(T_CL - 1)) && !curWrite;

  // length of the current column-strobe low run, for checking only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) casRun <= '0;
    else if (!dramCasN) casRun <= casRun + 1'b1;
    else casRun <= '0;
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady); // R8
  AST_HIT_NO_RAS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && state == ST_OPEN && rowHit) |=> (!dramRasN && !dramCasN)); // R3
  AST_PRE_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && state == ST_OPEN && !rowHit) |=> (dramRasN && dramCasN)); // R4
  AST_IDLE_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && !accept) |=> !dramRasN); // R9
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramCasN) |-> (casRun == 8'(T_CAS))); // R5
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> ($past(!dramRasN) || $past(state == ST_OPEN))); // R11

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_CL   = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dramAddr,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic                   dramDoutEn,
  output logic [DATA_W-1:0]      dramDout,
  input  logic [DATA_W-1:0]      dramDin
);
  fpmStrobe_t strb;
  logic       rowHit;
  logic       curWrite;

  fpm_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CL(T_CL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .curWrite(curWrite), .reqReady(reqReady), .strb(strb),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramDoutEn(dramDoutEn)
  );

  fpm_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .dramDin(dramDin),
    .rowHit(rowHit), .curWrite(curWrite), .dramAddr(dramAddr),
    .dramDout(dramDout), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;
  localparam int ROW_W = 8, COL_W = 6, DATA_W = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_CL = 2;
  localparam int NVEC = 11;

  // {write, row, col, wdata, kind}; kind 0 closed, 1 hit, 2 miss
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 8'h12, 6'h05, 16'h0000, 2'd0},
    {1'b0, 8'h12, 6'h06, 16'h0000, 2'd1},
    {1'b1, 8'h12, 6'h07, 16'hBEEF, 2'd1},
    {1'b0, 8'h12, 6'h07, 16'h0000, 2'd1},
    {1'b0, 8'h34, 6'h01, 16'h0000, 2'd2},
    {1'b1, 8'h34, 6'h3F, 16'h1234, 2'd1},
    {1'b0, 8'h12, 6'h07, 16'h0000, 2'd2},
    {1'b0, 8'h12, 6'h00, 16'h0000, 2'd1},
    {1'b1, 8'hFF, 6'h00, 16'h0F0F, 2'd2},
    {1'b0, 8'hFF, 6'h00, 16'h0000, 2'd1},
    {1'b0, 8'h00, 6'h3F, 16'h0000, 2'd2}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [ROW_W+COL_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rdValid, dramRasN, dramCasN, dramWeN, dramDoutEn;
  logic [DATA_W-1:0] rdData, dramDout, dramDin;
  logic [7:0] dramAddr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  fpm_dram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramDoutEn(dramDoutEn), .dramDout(dramDout), .dramDin(dramDin)
  );

  // DRAM model, sampled at the falling clock edge
  logic [15:0] mem [64];
  logic prevRas = 1, prevCas = 1;
  int rasFalls = 0, casFalls = 0, rasRun = 0, casRun = 0, weRun = 0;
  int lastRasHigh = 0, lastCasLen = 0, lastWeLen = 0, casNoRas = 0;
  logic [7:0] latRow = '0;
  logic [5:0] latCol = '0;
  logic [15:0] lastWrData = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'hA500 ^ 16'(i * 37);

  assign dramDin = (!dramCasN && dramWeN) ? mem[{latRow[2:0], latCol[2:0]}] : 16'hDEAD;

  always @(negedge clk) begin
    if (!dramCasN && dramRasN) casNoRas++;
    if (prevRas && !dramRasN) begin
      rasFalls++; latRow = dramAddr; lastRasHigh = rasRun; rasRun = 0;
    end
    if (dramRasN) rasRun++;
    if (prevCas && !dramCasN) begin
      casFalls++; latCol = dramAddr[5:0];
      if (!dramWeN && dramDoutEn) begin
        lastWrData = dramDout; mem[{latRow[2:0], dramAddr[2:0]}] = dramDout;
      end
    end
    if (!dramCasN) begin
      casRun++;
      if (!dramWeN && dramDoutEn && dramDout == lastWrData) weRun++;
    end else if (!prevCas) begin
      lastCasLen = casRun; lastWeLen = weRun; casRun = 0; weRun = 0;
    end
    prevRas = dramRasN; prevCas = dramCasN;
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [7:0] row, input logic [5:0] col,
                       input logic [15:0] data, input int kind);
    int r0, c0, base, rdLat, rdyLat, rdCnt, j;
    logic [15:0] expRd, gotRd;
    string latReq;
    expRd = mem[{row[2:0], col[2:0]}];
    while (!reqReady) tick();
    r0 = rasFalls; c0 = casFalls;
    reqValid = 1; reqWrite = wr; reqAddr = {row, col}; reqWdata = data;
    tick();
    reqValid = 0;
    check(reqReady == 0, "R8 busy", reqReady, 0);
    rdLat = -1; rdyLat = -1; rdCnt = 0; gotRd = '0; j = 1;
    while (j < 40) begin
      if (rdValid) begin
        rdCnt++;
        if (rdLat < 0) begin rdLat = j - 1; gotRd = rdData; end
      end
      if (reqReady) begin rdyLat = j - 1; break; end
      tick(); j++;
    end
    base   = (kind == 0) ? T_RCD : (kind == 1) ? 0 : T_RP + T_RCD;
    latReq = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
    check(rdyLat == base + T_CAS, "R8 ready return", rdyLat, base + T_CAS);
    check(rasFalls - r0 == (kind == 1 ? 0 : 1), {latReq, " row strobe falls"},
          rasFalls - r0, kind == 1 ? 0 : 1);
    check(casFalls - c0 == 1 && lastCasLen == T_CAS, "R5 column pulse", lastCasLen, T_CAS);
    if (kind != 1) check(latRow == row, "R2 row address", latRow, row);
    check(latCol == col, "R2 column address", latCol, col);
    if (kind == 2) check(lastRasHigh == T_RP, "R4 precharge", lastRasHigh, T_RP);
    if (wr) begin
      check(rdLat == -1, "R7 no read strobe", rdLat, -1);
      check(lastWrData == data, "R7 write data", lastWrData, data);
      check(lastWeLen == T_CAS, "R7 write enable width", lastWeLen, T_CAS);
    end else begin
      check(rdLat == base + T_CL, {latReq, " read latency"}, rdLat, base + T_CL);
      check(gotRd == expRd, "R6 read data", gotRd, expRd);
      check(rdCnt == 1, "R6 single strobe", rdCnt, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    check(dramRasN && dramCasN && dramWeN && !dramDoutEn && !rdValid && reqReady,
          "R1 in reset", {dramRasN, dramCasN, dramWeN, dramDoutEn, rdValid, reqReady}, 6'b111001);
    rstN = 1;
    tick(); tick();
    check(dramRasN && dramCasN && dramWeN && !rdValid && reqReady, "R1 after reset",
          {dramRasN, dramCasN, dramWeN, rdValid, reqReady}, 5'b11101);

    for (int v = 0; v < NVEC; v++)
      doReq(VEC[v][32], VEC[v][31:24], VEC[v][23:18], VEC[v][17:2], int'(VEC[v][1:0]));

    // R9: long idle keeps the row open, then a hit
    begin
      int r0;
      r0 = rasFalls;
      repeat (25) tick();
      check(!dramRasN && rasFalls == r0, "R9 row held open", dramRasN, 0);
      doReq(1'b0, 8'h00, 6'h01, 16'h0, 1);
    end

    // R10: reset closes the open row; next access reopens it
    @(negedge clk); rstN = 0;
    tick();
    check(dramRasN && reqReady, "R10 reset closes row", dramRasN, 1);
    rstN = 1;
    tick();
    doReq(1'b0, 8'h00, 6'h02, 16'h0, 0);

    check(casNoRas == 0, "R11 column strobe under row strobe", casNoRas, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule